// File: doc/BRIEF.md
# Signed Quotient Accumulator

This block assembles the quotient of a signed integer division without touching the operands. A separate engine produces the magnitude arithmetic. It reports the outcome of each trial subtraction as a single flag, most significant quotient bit first. The block takes in only the sign bits of the dividend and divisor when a division starts. It then collects exactly `WORD_W` step flags, shifting each one in as a quotient bit. Finally it applies the sign correction and offers the `WORD_W`-bit two's-complement quotient.

All three channels use ready/valid handshakes: operand signs in, step flags in, and quotient out. The quotient truncates toward zero. A division whose step flags are all ones is treated as a divide by zero: it yields -1 when the signs agree and +1 when exactly one sign is set. A new division may be accepted in the same cycle that the finished quotient is taken.

Top module: `signed_quotient_builder`

## Requirements
- R1: A synchronous clear (`rst` high at a clock edge) leaves the block idle after that edge: `in_ready` = 1, `step_ready` = 0, `out_valid` = 0.
- R2: `in_ready` is high only while idle, or while a finished quotient is offered and `out_ready` is high. An input handshake captures only the two sign bits.
- R3: `step_ready` is high only while fewer than `WORD_W` flags have been accepted for the current division. Exactly `WORD_W` flags are consumed per division.
- R4: Each accepted flag shifts the unsigned magnitude left by one and enters as its least significant bit. The first flag therefore becomes bit `WORD_W-1`.
- R5: The quotient is the magnitude when the sign bits are equal, and its two's complement (modulo 2^`WORD_W`) when exactly one sign bit is 1. This gives 22/7=3, -22/7=-3, 22/-7=-3 and -22/-7=3.
- R6: `out_valid` rises in the cycle after the last flag is accepted. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `quotient` stays constant.
- R7: `step_ok` values presented while `step_ready` is low, or with `step_valid` low, have no effect on the quotient.
- R8: When a quotient is taken and a new input is offered in the same cycle, both handshakes complete, and the block starts collecting flags in the next cycle.
- R9: An all-ones flag stream gives all-ones (-1) with equal signs, and 1 with exactly one sign set. An all-zeros stream gives 0 for any signs.
- R10: A clear during flag collection abandons that division, and no quotient is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear, active high |
| in_valid | input | 1 | Operand signs are offered |
| in_ready | output | 1 | Block accepts operand signs |
| dvd_sign | input | 1 | Sign bit of the dividend |
| dvs_sign | input | 1 | Sign bit of the divisor |
| step_valid | input | 1 | A step flag is offered |
| step_ready | output | 1 | Block accepts a step flag |
| step_ok | input | 1 | 1 when the trial step succeeded |
| out_valid | output | 1 | Quotient is offered |
| out_ready | input | 1 | Consumer takes the quotient |
| quotient | output | WORD_W | Signed quotient, two's complement |

## Verification
Two events can land on the same clock edge: delivery of a finished quotient and acceptance of the next division's signs. The bench provokes this by holding `out_ready` high and offering new signs right after the last flag. At that point it confirms that `in_ready` is already high while `out_valid` is high. The scoreboard must then pop the old quotient unchanged, and the following division must build from an empty magnitude. A second phase stalls `out_ready` in a repeating pattern, so that the overlap and the hold rule of R6 are both exercised against queued expected quotients.

// File: rtl/sqb_pkg.sv
package sqb_pkg;
   typedef enum logic [1:0] {
      SQB_IDLE = 2'd0,
      SQB_STEP = 2'd1,
      SQB_DONE = 2'd2
   } sqb_state_e;
endpackage

// File: rtl/sqb_step_counter.sv
// Counts accepted step flags for one division and flags the final one.
module sqb_step_counter #(
   parameter int WORD_W = 8,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic advance,
   output logic last
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || start)
         cnt_q <= '0;
      else if (advance)
         cnt_q <= cnt_q + 1'b1;
   end

   assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/sqb_mag_shift.sv
// Unsigned magnitude register; flags enter at the bottom, MSB first.
module sqb_mag_shift #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              advance,
   input  logic              bit_in,
   output logic [WORD_W-1:0] mag_q,
   output logic [WORD_W-1:0] mag_next
);
   assign mag_next = {mag_q[WORD_W-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (rst || start)
         mag_q <= '0;
      else if (advance)
         mag_q <= mag_next;
   end
endmodule

// File: rtl/sqb_sign_out.sv
// Sign correction; REG_OUT selects a registered or a combinational result.
module sqb_sign_out #(
   parameter int WORD_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture,
   input  logic              negate,
   input  logic [WORD_W-1:0] mag_in,
   output logic [WORD_W-1:0] q
);
   logic [WORD_W-1:0] fixed;

   assign fixed = negate ? (~mag_in + 1'b1) : mag_in;

   generate
      if (REG_OUT) begin : g_reg
         logic [WORD_W-1:0] q_r;
         always_ff @(posedge clk) begin
            if (rst)
               q_r <= '0;
            else if (capture)
               q_r <= fixed;
         end
         assign q = q_r;
      end else begin : g_comb
         assign q = fixed;
      end
   endgenerate
endmodule

// File: rtl/signed_quotient_builder.sv
module signed_quotient_builder #(
   parameter int WORD_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              dvd_sign,
   input  logic              dvs_sign,
   input  logic              step_valid,
   output logic              step_ready,
   input  logic              step_ok,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] quotient
);
   import sqb_pkg::*;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("signed_quotient_builder: WORD_W must be at least 2");
      end
   endgenerate

   sqb_state_e        st_q, st_d;
   logic              neg_q;
   logic              in_hs, step_hs, out_hs;
   logic              last_step;
   logic              finish;
   logic [WORD_W-1:0] mag_q, mag_next, mag_sel;

   assign in_ready   = (st_q == SQB_IDLE) || ((st_q == SQB_DONE) && out_ready);
   assign step_ready = (st_q == SQB_STEP);
   assign out_valid  = (st_q == SQB_DONE);

   assign in_hs   = in_valid && in_ready;
   assign step_hs = step_valid && step_ready;
   assign out_hs  = out_valid && out_ready;
   assign finish  = step_hs && last_step;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQB_IDLE: if (in_hs)  st_d = SQB_STEP;
         SQB_STEP: if (finish) st_d = SQB_DONE;
         SQB_DONE: if (out_hs) st_d = in_hs ? SQB_STEP : SQB_IDLE;
         default:              st_d = SQB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= SQB_IDLE;
         neg_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (in_hs)
            neg_q <= dvd_sign ^ dvs_sign;
      end
   end

   sqb_step_counter #(.WORD_W(WORD_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .start   (in_hs),
      .advance (step_hs),
      .last    (last_step)
   );

   sqb_mag_shift #(.WORD_W(WORD_W)) u_mag (
      .clk      (clk),
      .rst      (rst),
      .start    (in_hs),
      .advance  (step_hs),
      .bit_in   (step_ok),
      .mag_q    (mag_q),
      .mag_next (mag_next)
   );

   assign mag_sel = REG_OUT ? mag_next : mag_q;

   sqb_sign_out #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_sign (
      .clk     (clk),
      .rst     (rst),
      .capture (finish),
      .negate  (neg_q),
      .mag_in  (mag_sel),
      .q       (quotient)
   );
endmodule

// File: rtl/sqb_checker.sv
module sqb_checker #(
   parameter int WORD_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              step_valid,
   input logic              step_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] quotient
);
   logic [15:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst || (in_valid && in_ready))
         seen_q <= '0;
      else if (step_valid && step_ready)
         seen_q <= seen_q + 16'd1;
   end

   a_r1_clear_state: assert property (@(posedge clk)
      rst |=> (in_ready && !step_ready && !out_valid));

   a_r2_phase_split: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> !step_ready);

   a_r3_token_limit: assert property (@(posedge clk) disable iff (rst)
      step_ready |-> (seen_q < 16'(WORD_W)));

   a_r3_full_count: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (seen_q == 16'(WORD_W)));

   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(quotient)));

   a_r8_overlap: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && out_valid) |=> (step_ready && !out_valid));
endmodule

bind signed_quotient_builder sqb_checker #(.WORD_W(WORD_W)) u_sqb_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .step_valid (step_valid),
   .step_ready (step_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .quotient   (quotient)
);

// File: tb/signed_quotient_builder_bench.sv
module signed_quotient_builder_bench;
   localparam int W      = 8;
   localparam int CLK_PD = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0, dvd_sign = 1'b0, dvs_sign = 1'b0;
   logic         step_valid = 1'b0, step_ok = 1'b0;
   logic         out_ready = 1'b0;
   logic         in_ready, step_ready, out_valid;
   logic [W-1:0] quotient;

   int           checks = 0, errors = 0;
   int           ready_mode = 0;
   int           cyc = 0;
   logic [W-1:0] exp_q[$];
   bit           done_all = 1'b0;

   always #(CLK_PD/2) clk = ~clk;

   signed_quotient_builder #(.WORD_W(W)) u_signed_quotient_builder (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_ready(in_ready),
      .dvd_sign(dvd_sign), .dvs_sign(dvs_sign),
      .step_valid(step_valid), .step_ready(step_ready), .step_ok(step_ok),
      .out_valid(out_valid), .out_ready(out_ready), .quotient(quotient)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // Monitor: drives out_ready, pops the scoreboard on each output handshake.
   logic [W-1:0] held_q;
   bit           holding = 1'b0;
   always @(negedge clk) begin
      cyc++;
      out_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      #1;
      if (holding && !rst) begin
         chk(out_valid && (quotient == held_q), "R6 hold while stalled", int'(quotient), int'(held_q));
      end
      holding = 1'b0;
      if (!rst && out_valid && out_ready) begin
         if (exp_q.size() == 0)
            chk(1'b0, "R3 unexpected quotient", int'(quotient), 0);
         else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(quotient == e, "R4/R5 quotient value", int'(quotient), int'(e));
         end
      end else if (!rst && out_valid) begin
         holding = 1'b1;
         held_q  = quotient;
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done_all) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // Tasks start and end just after a falling edge.
   task automatic send_in(input bit ds, input bit vs);
      in_valid = 1'b1; dvd_sign = ds; dvs_sign = vs;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      in_valid = 1'b0; dvd_sign = 1'b0; dvs_sign = 1'b0;
      #1;
   endtask

   task automatic send_steps(input logic [W-1:0] bits, input int gap);
      for (int i = W - 1; i >= 0; i--) begin
         for (int g = 0; g < gap; g++) begin
            step_valid = 1'b0; step_ok = ~bits[i];   // R7 noise without valid
            @(negedge clk); #1;
         end
         step_valid = 1'b1; step_ok = bits[i];
         while (!step_ready) begin @(negedge clk); #1; end
         @(negedge clk);
         step_valid = 1'b0; step_ok = 1'b0;
         #1;
      end
      chk(out_valid === 1'b1, "R6 valid one cycle after last flag", int'(out_valid), 1);
      chk(step_ready === 1'b0, "R3 no flag beyond WORD_W", int'(step_ready), 0);
   endtask

   function automatic logic [W-1:0] model(input bit ds, input bit vs, input logic [W-1:0] m);
      return (ds ^ vs) ? (~m + 1'b1) : m;
   endfunction

   task automatic run_div(input bit ds, input bit vs, input logic [W-1:0] bits, input int gap);
      send_in(ds, vs);
      send_steps(bits, gap);
      exp_q.push_back(model(ds, vs, bits));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk(in_ready === 1'b1,   "R1 in_ready after clear",   int'(in_ready), 1);
      chk(step_ready === 1'b0, "R1 step_ready after clear", int'(step_ready), 0);
      chk(out_valid === 1'b0,  "R1 out_valid after clear",  int'(out_valid), 0);

      // R7: flags offered before any division are not taken.
      step_valid = 1'b1; step_ok = 1'b1;
      @(negedge clk); #1;
      chk(step_ready === 1'b0, "R7 flag refused while idle", int'(step_ready), 0);
      @(negedge clk); step_valid = 1'b0; step_ok = 1'b0; #1;

      // R5: 22/7 family, magnitude 3 (expected 03 or FD).
      run_div(1'b0, 1'b0, 8'd3, 0);
      // R8: next signs offered while the quotient is delivered.
      chk(in_ready && out_valid, "R8 overlap ready", int'({in_ready, out_valid}), 3);
      run_div(1'b1, 1'b0, 8'd3, 0);
      run_div(1'b0, 1'b1, 8'd3, 0);
      run_div(1'b1, 1'b1, 8'd3, 0);
      // R9: small dividend gives zero; all-ones gives -1 or +1.
      run_div(1'b1, 1'b1, 8'd0, 0);
      run_div(1'b0, 1'b1, 8'd0, 0);
      run_div(1'b0, 1'b0, 8'hFF, 0);
      run_div(1'b1, 1'b0, 8'hFF, 0);
      run_div(1'b0, 1'b1, 8'hFF, 1);
      // R4: bit order, MSB first.
      run_div(1'b0, 1'b0, 8'h80, 0);
      run_div(1'b0, 1'b0, 8'h01, 2);

      // Stalled consumer with random flags and gaps.
      ready_mode = 1;
      for (int k = 0; k < 40; k++) begin
         run_div(1'($urandom), 1'($urandom), 8'($urandom), k % 3);
      end
      while (exp_q.size() != 0) begin @(negedge clk); #1; end
      ready_mode = 0;
      @(negedge clk); #1;

      // R10: clear in the middle of collecting flags.
      send_in(1'b1, 1'b0);
      for (int i = 0; i < 3; i++) begin
         step_valid = 1'b1; step_ok = 1'b1;
         @(negedge clk); #1;
      end
      step_valid = 1'b0; step_ok = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(in_ready === 1'b1 && step_ready === 1'b0 && out_valid === 1'b0,
          "R10 division abandoned", int'({in_ready, step_ready, out_valid}), 4);
      run_div(1'b0, 1'b0, 8'h05, 0);
      while (exp_q.size() != 0) begin @(negedge clk); #1; end
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid === 1'b0, "R10 no extra quotient", int'(out_valid), 0);

      done_all = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule